// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point filter engine. In every cycle where accumulation is enabled it multiplies two signed 16-bit operands, typically a coefficient and a sample. It sign-extends the 32-bit product and adds it into a 40-bit accumulator. The 8 bits above the product width act as guard bits, so a long run of taps can build up without overflow. One tap is retired per clock.

The accumulator can be cleared or loaded with a preset value. A synchronous clear wins over a load, and a load wins over an accumulate. When the saturation enable is set, a sum that leaves the 40-bit range is clamped to the nearest limit. When it is clear, the sum wraps.

The result port is combinational from the accumulator. It shows either the whole 40-bit value or a 16-bit high word. The high word is taken after an optional one-bit left shift, which realigns fractional (Q15 times Q15) results. It is clamped to the 16-bit signed range and sign-extended onto the port. A valid flag marks the cycle after each accumulate request.

Top module: `sat_mac`

## Requirements
- R1: After reset the accumulator is zero, `valid` is 0, and `result` reads 0 with `out_hi`=0.
- R2: When `acc_en`=1, `clr`=0 and `ld`=0, the accumulator becomes its old value plus the two's-complement product of `a` and `b`, sign-extended to 40 bits. One product is added per clock edge.
- R3: `clr`=1 makes the accumulator zero at the next edge, whatever `ld` and `acc_en` hold.
- R4: `ld`=1 with `clr`=0 loads `ld_val` into the accumulator at the next edge, and `acc_en` in that cycle is ignored.
- R5: With `clr`, `ld` and `acc_en` all 0, the accumulator holds its value.
- R6: With `sat_en`=1, a sum above 2^39-1 gives 40'h7F_FFFF_FFFF and a sum below -2^39 gives 40'h80_0000_0000.
- R7: With `sat_en`=0, an out-of-range sum keeps its low 40 bits (wraps).
- R8: With `out_hi`=0, `result` equals the 40-bit accumulator.
- R9: With `out_hi`=1, let v be the accumulator times 2 when `shl1`=1, or the accumulator itself when `shl1`=0. v is shifted right arithmetically by 16 and clamped to [-32768, 32767]. The outcome appears sign-extended to 40 bits on `result`.
- R10: `valid` equals `acc_en` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the accumulator (highest priority) |
| ld | input | 1 | Load `ld_val` into the accumulator |
| ld_val | input | 40 | Preset value for a load |
| acc_en | input | 1 | Add the product of `a` and `b` this cycle |
| sat_en | input | 1 | 1 clamps an overflowing sum, 0 lets it wrap |
| a | input | 16 | Signed operand (coefficient) |
| b | input | 16 | Signed operand (sample) |
| out_hi | input | 1 | 0 shows the full accumulator, 1 shows the clamped high word |
| shl1 | input | 1 | Shift left by one before the high word is taken |
| result | output | 40 | Selected accumulator view |
| valid | output | 1 | Accumulate request of the previous cycle |

## Verification
The bench targets the signed extremes of the operands, including -32768 times -32768. A design that multiplies unsigned values or zero-extends the product gives a wrong sum there. It also pushes the accumulator across both 40-bit limits with saturation on and off. A design that clamps when it should wrap, or that judges overflow from the wrong bit, turns a large positive total negative or leaves it at the limit. The control inputs are asserted together to check the clear-over-load-over-accumulate order. High-word reads sit just inside and just outside the 16-bit range, with and without the shift. A missed clamp or a wrong shift shows up there as a wrapped or misaligned word.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_ACC   = 2'd3
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    localparam int PROD_W = A_W + B_W
) (
    input  logic [A_W-1:0]    a,
    input  logic [B_W-1:0]    b,
    output logic [PROD_W-1:0] prod
);

    logic signed [PROD_W-1:0] prod_s;

    always_comb begin
        prod_s = $signed(a) * $signed(b);
        prod   = prod_s;
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int PROD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mac_op_e           op,
    input  logic              sat_en,
    input  logic [PROD_W-1:0] prod,
    input  logic [ACC_W-1:0]  ld_val,
    output logic [ACC_W-1:0]  acc
);

    localparam int EXT_W = ACC_W + 1 - PROD_W;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   prod_ext;
    logic [ACC_W:0]   sum;
    logic             ovf;
    logic [ACC_W-1:0] sum_fix;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;

    always_comb begin
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        sum      = {acc_q[ACC_W-1], acc_q} + prod_ext;
        ovf      = sum[ACC_W] ^ sum[ACC_W-1];
        if (ovf && sat_en) begin
            sum_fix = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            sum_fix = sum[ACC_W-1:0];
        end
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: acc_nxt = '0;
            OP_LOAD:  acc_nxt = ld_val;
            OP_ACC:   acc_nxt = sum_fix;
            default:  acc_nxt = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    assign acc = acc_q;

    // R6
    sat_pos_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACC && sat_en && !acc_q[ACC_W-1] && !prod[PROD_W-1])
        |=> !acc_q[ACC_W-1]);

    // R6
    sat_neg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACC && sat_en && acc_q[ACC_W-1] && prod[PROD_W-1])
        |=> acc_q[ACC_W-1]);

endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
    parameter int ACC_W  = 40,
    parameter int OUT_W  = 16,
    parameter int DROP_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             out_hi,
    input  logic             shl1,
    output logic [ACC_W-1:0] result
);

    localparam int HI_W  = ACC_W + 1 - DROP_W;
    localparam int TOP_W = HI_W - OUT_W + 1;

    logic [ACC_W:0]   v;
    logic [HI_W-1:0]  hi;
    logic [TOP_W-1:0] top;
    logic             fits;
    logic [OUT_W-1:0] word;

    always_comb begin
        v    = shl1 ? {acc, 1'b0} : {acc[ACC_W-1], acc};
        hi   = v[ACC_W:DROP_W];
        top  = hi[HI_W-1:OUT_W-1];
        fits = (&top) | ~(|top);
        if (fits) begin
            word = hi[OUT_W-1:0];
        end else if (hi[HI_W-1]) begin
            word = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            word = {1'b0, {(OUT_W-1){1'b1}}};
        end
        result = out_hi ? {{(ACC_W-OUT_W){word[OUT_W-1]}}, word} : acc;
    end

    // R9
    always_comb begin
        hi_range_chk: assert (!out_hi || !shl1 || acc[ACC_W-1] || !result[ACC_W-1]);
    end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import mac_pkg::*;
#(
    parameter int A_W   = 16,
    parameter int B_W   = 16,
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [ACC_W-1:0] ld_val,
    input  logic             acc_en,
    input  logic             sat_en,
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    input  logic             out_hi,
    input  logic             shl1,
    output logic [ACC_W-1:0] result,
    output logic             valid
);

    localparam int PROD_W = A_W + B_W;
    localparam int DROP_W = PROD_W / 2;

    mac_op_e          op;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;

    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (ld) begin
            op = OP_LOAD;
        end else if (acc_en) begin
            op = OP_ACC;
        end else begin
            op = OP_HOLD;
        end
    end

    mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
        .a    (a),
        .b    (b),
        .prod (prod)
    );

    mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .sat_en (sat_en),
        .prod   (prod),
        .ld_val (ld_val),
        .acc    (acc)
    );

    mac_extract #(.ACC_W(ACC_W), .OUT_W(OUT_W), .DROP_W(DROP_W)) u_extract (
        .acc    (acc),
        .out_hi (out_hi),
        .shl1   (shl1),
        .result (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= acc_en;
        end
    end

    // R3
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (acc == $past(ld_val)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !acc_en) |=> $stable(acc));

    // R10
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> valid);

    // R10
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !valid);

endmodule

// File: tb/test_sat_mac.sv
module test_sat_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, ld = 1'b0, acc_en = 1'b0, sat_en = 1'b0;
    logic        out_hi = 1'b0, shl1 = 1'b0;
    logic [39:0] ld_val = '0;
    logic [15:0] a = '0, b = '0;
    logic [39:0] result;
    logic        valid;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [39:0] res;
        logic        vld;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    longint acc_m = 0;

    always #4 clk = ~clk;

    sat_mac i_sat_mac (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_val(ld_val),
        .acc_en(acc_en), .sat_en(sat_en), .a(a), .b(b),
        .out_hi(out_hi), .shl1(shl1), .result(result), .valid(valid)
    );

    function automatic longint sx40(input logic [39:0] x);
        return longint'($signed(x));
    endfunction

    function automatic logic [39:0] view(input longint acc, input bit hi, input bit sh);
        longint v;
        longint h;
        if (!hi) return 40'(acc);
        v = sh ? acc * 2 : acc;
        h = v >>> 16;
        if (h > 32767) h = 32767;
        if (h < -32768) h = -32768;
        return 40'(h);
    endfunction

    // Called at a falling edge; applies one cycle of stimulus and queues the outcome.
    task automatic drive(input bit c, input bit l, input logic [39:0] lv, input bit en,
                         input bit s, input logic [15:0] av, input logic [15:0] bv,
                         input bit hi, input bit sh, input string tag);
        longint sum;
        longint w;
        exp_t e;
        clr = c; ld = l; ld_val = lv; acc_en = en; sat_en = s;
        a = av; b = bv; out_hi = hi; shl1 = sh;
        if (c) begin
            acc_m = 0;
        end else if (l) begin
            acc_m = sx40(lv);
        end else if (en) begin
            sum = acc_m + longint'($signed(av)) * longint'($signed(bv));
            if (s) begin
                if (sum > 64'sh7F_FFFF_FFFF) sum = 64'sh7F_FFFF_FFFF;
                if (sum < -64'sh80_0000_0000) sum = -64'sh80_0000_0000;
                acc_m = sum;
            end else begin
                w = sum & 64'hFF_FFFF_FFFF;
                if (w >= 64'sh80_0000_0000) w = w - 64'sh100_0000_0000;
                acc_m = w;
            end
        end
        e.res = view(acc_m, hi, sh);
        e.vld = en;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                nvec++;
                if (result !== e.res || valid !== e.vld) begin
                    nbad++;
                    $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                             e.tag, result, valid, e.res, e.vld);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                nbad++;
                nvec++;
                $display("FAIL watchdog: cycles=%0d expected completion", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        nvec++;
        if (result !== 40'h0 || valid !== 1'b0) begin
            nbad++;
            $display("FAIL R1: result=%h valid=%b expected result=%h valid=0", result, valid, 40'h0);
        end

        // R2 signed products, R8 full view, R10 valid
        drive(0, 0, '0, 1, 1, 16'd3, 16'd4, 0, 0, "R2 3*4");
        drive(0, 0, '0, 1, 1, -16'sd5, 16'd7, 0, 0, "R2 -5*7");
        drive(0, 0, '0, 1, 0, 16'h8000, 16'h8000, 0, 0, "R2 min*min");
        // R3 clear beats load and accumulate
        drive(1, 1, 40'h12_3456_789A, 1, 1, 16'd9, 16'd9, 0, 0, "R3 clear priority");
        // R4 load, then load with accumulate request
        drive(0, 1, 40'h7F_FFFF_0000, 0, 0, '0, '0, 0, 0, "R4 load");
        drive(0, 1, 40'h12_3456_789A, 1, 1, 16'd1, 16'd1, 0, 0, "R4 load beats acc");
        // R5 idle hold
        drive(0, 0, 40'hFF_FFFF_FFFF, 0, 1, 16'd100, 16'd100, 0, 0, "R5 hold");
        // R6 positive clamp
        drive(0, 1, 40'h7F_FFFF_F000, 0, 1, '0, '0, 0, 0, "R6 preload");
        drive(0, 0, '0, 1, 1, 16'h7FFF, 16'h7FFF, 0, 0, "R6 clamp max");
        // R7 wrap
        drive(0, 1, 40'h7F_FFFF_F000, 0, 0, '0, '0, 0, 0, "R7 preload");
        drive(0, 0, '0, 1, 0, 16'h7FFF, 16'h7FFF, 0, 0, "R7 wrap");
        // R6 negative clamp
        drive(0, 1, 40'h80_0000_1000, 0, 1, '0, '0, 0, 0, "R6 preload neg");
        drive(0, 0, '0, 1, 1, 16'h8000, 16'h7FFF, 0, 0, "R6 clamp min");
        // R9 high word views
        drive(0, 1, 40'h00_4000_0000, 0, 0, '0, '0, 1, 0, "R9 hi noshift");
        drive(0, 0, '0, 0, 0, '0, '0, 1, 1, "R9 hi shift clamp pos");
        drive(0, 1, 40'hFF_BFFF_FFFF, 0, 0, '0, '0, 1, 1, "R9 hi shift clamp neg");
        drive(0, 0, '0, 0, 0, '0, '0, 1, 0, "R9 hi noshift neg");
        drive(0, 1, 40'h00_1234_5678, 0, 0, '0, '0, 1, 1, "R9 hi shift fits");
        drive(0, 0, '0, 1, 0, 16'd2, 16'd3, 0, 0, "R8 full after acc");
        drive(0, 0, '0, 0, 0, '0, '0, 0, 0, "R10 valid drops");

        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        done = 1'b1;
        $finish;
    end

endmodule